// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is an SPI master with a small register interface, a byte-wide transmit queue and a byte-wide receive queue. Software first programs the serial clock divider, the clock polarity and phase, and the byte counts. It then loads the transmit queue and sets the exchange bit in the control register. The engine runs a burst: it shifts out the programmed number of bytes, most significant bit first, and captures one received byte into the receive queue for each byte it sends. The exchange bit reads back as 1 until the last byte has been captured. Software polls that bit and then drains the receive queue.

A burst can send fewer queued bytes than its total length. Positions beyond the transmit count are sent as zero bytes, and so are positions reached when the transmit queue is empty. The chip-select lines can follow the exchange automatically. Software can also drive them by hand, choosing both the line and the level. Each queue is flushed by a control bit that clears itself. Register reads are combinational. Reading the receive-data offset pops one byte.

Top module: `spim_burst_core`

## Requirements
- R1: After reset the control register reads 0x0000_0010, meaning chip select is active low and everything else is off. The clock, burst-count, transmit-count and status registers read 0. All chip-select lines are high and SCLK is low.
- R2: The burst count (offset 0x20) and the transmit count (offset 0x24) each hold 24 bits. A write keeps bits 23:0 and discards the bits above, which read back as 0.
- R3: A control write (offset 0x08) with bit 10 set starts a burst only if the same write also sets bit 0 (enable) and bit 1 (master). Bit 10 then reads 1 until the last byte is captured, after which it reads 0. Without enable or master set, bit 10 reads 0 and SCLK does not toggle.
- R4: Control bit 3 (CPOL) sets the SCLK idle level. With bit 2 (CPHA) at 0, MISO is sampled on the first edge of each bit. With CPHA at 1, it is sampled on the second edge. Bytes travel MSB first in both directions.
- R5: A burst position at or beyond the transmit count sends 0x00. A position reached while the transmit queue is empty also sends 0x00. In both cases the transmit queue is not popped.
- R6: Each burst byte pushes one received byte. Status bits 6:0 (offset 0x28) give the receive-queue fill. Reads of offset 0x00 return the received bytes in order, in bits 7:0.
- R7: The receive queue holds 64 bytes. A byte received while the queue is full is dropped, so the fill stays at 64 and the oldest 64 bytes are kept.
- R8: Control bit 8 empties the transmit queue and control bit 9 empties the receive queue. Both bits read 0 again from the second cycle after the write.
- R9: With control bit 16 set (manual mode), the chip-select line chosen by bits 13:12 takes the level in bit 17. All other lines sit at the inactive level, which is 1 when bit 4 is set and 0 otherwise.
- R10: With bit 16 clear, the selected line is at the active level (low when bit 4 is set) exactly while bit 10 reads 1. Every other line stays inactive.
- R11: Clock register bits 7:0 (offset 0x1C) hold a value N. Each SCLK half-period lasts N+1 system clock cycles.
- R12: Status bits 22:16 give the transmit-queue fill. Each write to offset 0x04 pushes bits 7:0 into the transmit queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x00) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip-select lines |

## Verification
Read data is valid in the same cycle as the read strobe, so the bench samples it 1 ns after it drives the strobe. A register write or queue push becomes visible from the next clock edge. Chip-select levels follow one edge after a control write, and the queue-flush bits are back to 0 by the second edge after the write. A burst lasts about (16·(N+1)+2) cycles per byte, so the bench polls the exchange bit instead of waiting a fixed time. The half-period check takes timestamps of SCLK edges, which land on clock edges, and divides the interval by the 8 ns period.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
   localparam logic [7:0] OFS_RXD   = 8'h00;
   localparam logic [7:0] OFS_TXD   = 8'h04;
   localparam logic [7:0] OFS_CTRL  = 8'h08;
   localparam logic [7:0] OFS_CLK   = 8'h1C;
   localparam logic [7:0] OFS_BURST = 8'h20;
   localparam logic [7:0] OFS_TXCNT = 8'h24;
   localparam logic [7:0] OFS_STAT  = 8'h28;

   localparam int BIT_EN    = 0;
   localparam int BIT_MST   = 1;
   localparam int BIT_CPHA  = 2;
   localparam int BIT_CPOL  = 3;
   localparam int BIT_CSLOW = 4;
   localparam int BIT_TFLSH = 8;
   localparam int BIT_RFLSH = 9;
   localparam int BIT_GO    = 10;
   localparam int BIT_CSIDX = 12;
   localparam int BIT_CSMAN = 16;
   localparam int BIT_CSLVL = 17;

   localparam int STAT_TX_LSB = 16;

   typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_RUN, ENG_BYTE} eng_state_t;

   typedef struct packed {
      logic       cs_level;
      logic       cs_manual;
      logic [1:0] cs_idx;
      logic       cs_low;
      logic       cpol;
      logic       cpha;
      logic       master;
      logic       enable;
   } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic [W-1:0]             wdata,
   input  logic                     pop,
   output logic [W-1:0]             rdata,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     full,
   output logic                     empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift
   import spim_pkg::*;
#(
   parameter int CNT_W = 24,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] burst_len,
   input  logic [CNT_W-1:0] tx_len,
   input  logic [DIV_W-1:0] div,
   input  logic             cpol,
   input  logic             cpha,
   input  logic [7:0]       tx_data,
   input  logic             tx_empty,
   output logic             tx_pop,
   output logic             rx_push,
   output logic [7:0]       rx_data,
   output logic             done,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso
);
   eng_state_t       st;
   logic [CNT_W-1:0] sent;
   logic [DIV_W-1:0] hp;
   logic [3:0]       edge_n;
   logic [7:0]       tsh, rsh;
   logic             sclk_q;
   logic             use_fifo, sample_now;
   logic [7:0]       next_byte;

   assign use_fifo   = (sent < tx_len) && !tx_empty;
   assign next_byte  = use_fifo ? tx_data : 8'h00;
   assign sample_now = (edge_n[0] == cpha);
   assign tx_pop     = (st == ENG_LOAD) && use_fifo;
   assign rx_push    = (st == ENG_BYTE);
   assign rx_data    = rsh;
   assign sclk       = (st == ENG_IDLE) ? cpol : sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ENG_IDLE;
         sent   <= '0;
         hp     <= '0;
         edge_n <= '0;
         tsh    <= '0;
         rsh    <= '0;
         sclk_q <= 1'b0;
         mosi   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ENG_IDLE: begin
               sclk_q <= cpol;
               if (start) begin
                  sent <= '0;
                  if (burst_len == '0) done <= 1'b1;
                  else                 st   <= ENG_LOAD;
               end
            end
            ENG_LOAD: begin
               hp     <= '0;
               edge_n <= '0;
               if (cpha) begin
                  tsh <= next_byte;
               end else begin
                  mosi <= next_byte[7];
                  tsh  <= {next_byte[6:0], 1'b0};
               end
               st <= ENG_RUN;
            end
            ENG_RUN: begin
               if (hp == div) begin
                  hp     <= '0;
                  sclk_q <= ~sclk_q;
                  edge_n <= edge_n + 4'd1;
                  if (sample_now) begin
                     rsh <= {rsh[6:0], miso};
                  end else begin
                     mosi <= tsh[7];
                     tsh  <= {tsh[6:0], 1'b0};
                  end
                  if (edge_n == 4'd15) st <= ENG_BYTE;
               end else begin
                  hp <= hp + DIV_W'(1);
               end
            end
            ENG_BYTE: begin
               sent <= sent + CNT_W'(1);
               if (sent + CNT_W'(1) == burst_len) begin
                  done <= 1'b1;
                  st   <= ENG_IDLE;
               end else begin
                  st <= ENG_LOAD;
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spim_burst_core.sv
`timescale 1ns/1ps
module spim_burst_core
   import spim_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int NUM_CS     = 4,
   parameter int CNT_W      = 24,
   parameter int DIV_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("spim_burst_core: NUM_CS must be 1..4");
   end
   if (CW > 8) begin : g_bad_depth
      $error("spim_burst_core: FIFO_DEPTH must not exceed 128");
   end
   if (CNT_W < 8 || CNT_W > 32 || DIV_W < 1 || DIV_W > CNT_W) begin : g_bad_w
      $error("spim_burst_core: CNT_W must be 8..32 and DIV_W 1..CNT_W");
   end

   ctrl_t            ctl;
   logic             xch_q, tfrst_q, rfrst_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] burst_q, txlen_q;
   logic             wr_ctrl, start;
   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic             rx_pop, rx_push_raw, rx_push, rx_full, rx_empty;
   logic [7:0]       tx_head, rx_head, rx_byte;
   logic [CW-1:0]    tx_count, rx_count;
   logic             eng_done;
   logic [31:0]      ctrl_rd, stat_rd;

   if (CNT_W < 32) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^reg_wdata[31:CNT_W];
   end

   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign start   = wr_ctrl && reg_wdata[BIT_GO] && reg_wdata[BIT_EN]
                    && reg_wdata[BIT_MST] && !xch_q;
   assign tx_push = reg_wr && (reg_addr == OFS_TXD) && !tx_full;
   assign rx_pop  = reg_rd && (reg_addr == OFS_RXD) && !rx_empty;
   assign rx_push = rx_push_raw && !rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '{cs_low: 1'b1, default: '0};
         xch_q   <= 1'b0;
         tfrst_q <= 1'b0;
         rfrst_q <= 1'b0;
         div_q   <= '0;
         burst_q <= '0;
         txlen_q <= '0;
      end else begin
         tfrst_q <= wr_ctrl && reg_wdata[BIT_TFLSH];
         rfrst_q <= wr_ctrl && reg_wdata[BIT_RFLSH];
         if (start)         xch_q <= 1'b1;
         else if (eng_done) xch_q <= 1'b0;
         if (wr_ctrl) begin
            ctl.enable    <= reg_wdata[BIT_EN];
            ctl.master    <= reg_wdata[BIT_MST];
            ctl.cpha      <= reg_wdata[BIT_CPHA];
            ctl.cpol      <= reg_wdata[BIT_CPOL];
            ctl.cs_low    <= reg_wdata[BIT_CSLOW];
            ctl.cs_idx    <= reg_wdata[BIT_CSIDX +: 2];
            ctl.cs_manual <= reg_wdata[BIT_CSMAN];
            ctl.cs_level  <= reg_wdata[BIT_CSLVL];
         end
         if (reg_wr && reg_addr == OFS_CLK)   div_q   <= reg_wdata[DIV_W-1:0];
         if (reg_wr && reg_addr == OFS_BURST) burst_q <= reg_wdata[CNT_W-1:0];
         if (reg_wr && reg_addr == OFS_TXCNT) txlen_q <= reg_wdata[CNT_W-1:0];
      end
   end

   spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_txq (
      .clk(clk), .rst_n(rst_n), .flush(tfrst_q),
      .push(tx_push), .wdata(reg_wdata[7:0]),
      .pop(tx_pop), .rdata(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rfrst_q),
      .push(rx_push), .wdata(rx_byte),
      .pop(rx_pop), .rdata(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   spim_shift #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_eng (
      .clk(clk), .rst_n(rst_n), .start(start),
      .burst_len(burst_q), .tx_len(txlen_q), .div(div_q),
      .cpol(ctl.cpol), .cpha(ctl.cpha),
      .tx_data(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
      .rx_push(rx_push_raw), .rx_data(rx_byte), .done(eng_done),
      .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign spi_cs[i] = (ctl.cs_idx != 2'(i)) ? ctl.cs_low :
                         ctl.cs_manual         ? ctl.cs_level :
                         (xch_q ? ~ctl.cs_low : ctl.cs_low);
   end

   always_comb begin
      ctrl_rd                  = '0;
      ctrl_rd[BIT_EN]          = ctl.enable;
      ctrl_rd[BIT_MST]         = ctl.master;
      ctrl_rd[BIT_CPHA]        = ctl.cpha;
      ctrl_rd[BIT_CPOL]        = ctl.cpol;
      ctrl_rd[BIT_CSLOW]       = ctl.cs_low;
      ctrl_rd[BIT_TFLSH]       = tfrst_q;
      ctrl_rd[BIT_RFLSH]       = rfrst_q;
      ctrl_rd[BIT_GO]          = xch_q;
      ctrl_rd[BIT_CSIDX +: 2]  = ctl.cs_idx;
      ctrl_rd[BIT_CSMAN]       = ctl.cs_manual;
      ctrl_rd[BIT_CSLVL]       = ctl.cs_level;
      stat_rd                  = '0;
      stat_rd[CW-1:0]          = rx_count;
      stat_rd[STAT_TX_LSB +: CW] = tx_count;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_RXD:   reg_rdata = {24'h0, rx_head};
         OFS_CTRL:  reg_rdata = ctrl_rd;
         OFS_CLK:   reg_rdata = 32'(div_q);
         OFS_BURST: reg_rdata = 32'(burst_q);
         OFS_TXCNT: reg_rdata = 32'(txlen_q);
         OFS_STAT:  reg_rdata = stat_rd;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_burst_chk.sv
`timescale 1ns/1ps
module spim_burst_chk #(
   parameter int NUM_CS = 4,
   parameter int DEPTH  = 64
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   xch,
   input logic                   eng_done,
   input logic                   tfrst,
   input logic                   rfrst,
   input logic                   cs_manual,
   input logic                   cs_low,
   input logic                   cpol,
   input logic                   sclk,
   input logic [NUM_CS-1:0]      cs,
   input logic [$clog2(DEPTH):0] rx_count,
   input logic                   rx_push,
   input logic                   rx_full,
   input logic                   rx_pop
);
   localparam int CW = $clog2(DEPTH) + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   p_xch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch) |-> $past(eng_done));

   p_sclk_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!xch && !$past(xch) && $stable(cpol)) |-> $stable(sclk));

   p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= FULL_CNT);

   p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_pop && !rfrst) |=> rx_count == FULL_CNT);

   p_tflush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tfrst |=> !tfrst);

   p_rflush_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rfrst |=> !rfrst);

   p_cs_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_manual |-> $onehot0(cs_low ? ~cs : cs));
endmodule

bind spim_burst_core spim_burst_chk #(.NUM_CS(NUM_CS), .DEPTH(FIFO_DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .xch(xch_q), .eng_done(eng_done),
   .tfrst(tfrst_q), .rfrst(rfrst_q),
   .cs_manual(ctl.cs_manual), .cs_low(ctl.cs_low), .cpol(ctl.cpol),
   .sclk(spi_sclk), .cs(spi_cs), .rx_count(rx_count),
   .rx_push(rx_push_raw), .rx_full(rx_full), .rx_pop(rx_pop)
);

// File: tb/test_spim_burst_core.sv
`timescale 1ns/1ps
module test_spim_burst_core;
   localparam logic [7:0] A_RXD = 8'h00, A_TXD = 8'h04, A_CTRL = 8'h08, A_CLK = 8'h1C;
   localparam logic [7:0] A_BURST = 8'h20, A_TXCNT = 8'h24, A_STAT = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sclk, spi_mosi, spi_miso;
   logic [3:0]  spi_cs;

   int checks = 0, fails = 0;
   bit finished = 0;

   logic [7:0] s_tx [256];
   logic [7:0] s_rx [256];
   int  s_bits = 0;
   int  sclk_edges = 0;
   bit  tb_cpol = 0, tb_cpha = 0;

   always #4 clk = ~clk;

   spim_burst_core i_spim_burst_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs(spi_cs)
   );

   // bench slave: presents MSB-first bytes, captures on the sampling edge
   assign spi_miso = s_tx[(s_bits >> 3) & 255][7 - (s_bits & 7)];

   always @(posedge spi_sclk or negedge spi_sclk) begin
      sclk_edges++;
      if ((spi_sclk != tb_cpol) == (tb_cpha == 1'b0)) begin
         s_rx[(s_bits >> 3) & 255][7 - (s_bits & 7)] = spi_mosi;
         s_bits++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic slave_reset(input int seed);
      s_bits = 0;
      for (int i = 0; i < 256; i++) begin
         s_tx[i] = 8'((i * 37 + seed * 11) ^ 8'h3C);
         s_rx[i] = 8'h00;
      end
   endtask

   task automatic wait_idle();
      logic [31:0] d = 32'h400;
      for (int k = 0; k < 6000; k++) begin
         rd(A_CTRL, d);
         if (!d[10]) break;
      end
      chk("R3 exchange bit clears after burst", 32'(d[10]), 0);
   endtask

   function automatic logic [31:0] cfg(input bit pol, input bit pha, input int idx);
      return 32'h13 | (32'(pha) << 2) | (32'(pol) << 3) | (32'(idx) << 12);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(A_CTRL, d);  chk("R1 control reset", d, 32'h10);
      rd(A_CLK, d);   chk("R1 clock reset", d, 0);
      rd(A_BURST, d); chk("R1 burst reset", d, 0);
      rd(A_TXCNT, d); chk("R1 txcount reset", d, 0);
      rd(A_STAT, d);  chk("R1 status reset", d, 0);
      chk("R1 cs idle high", 32'(spi_cs), 32'hF);
      chk("R1 sclk low", 32'(spi_sclk), 0);
   endtask

   task automatic t_counts();
      logic [31:0] d;
      wr(A_BURST, 32'hFFFF_FFFF); rd(A_BURST, d); chk("R2 burst upper bits dropped", d, 32'h00FF_FFFF);
      wr(A_TXCNT, 32'hAB12_3456); rd(A_TXCNT, d); chk("R2 txcount upper bits dropped", d, 32'h0012_3456);
   endtask

   task automatic t_mode(input bit pol, input bit pha, input int n);
      logic [31:0] d;
      int m = 2 * int'(pol) + int'(pha);
      wr(A_CLK, 1);
      wr(A_CTRL, cfg(pol, pha, 1) | 32'h300);
      @(negedge clk);
      tb_cpol = pol; tb_cpha = pha;
      slave_reset(m + 1);
      chk("R4 sclk idles at cpol", 32'(spi_sclk), 32'(pol));
      for (int i = 0; i < n; i++) wr(A_TXD, 32'(8'hA5 + i * 19 + m));
      wr(A_BURST, n); wr(A_TXCNT, n);
      wr(A_CTRL, cfg(pol, pha, 1) | 32'h400);
      rd(A_CTRL, d);
      chk("R3 exchange bit set while busy", 32'(d[10]), 1);
      chk("R10 selected line active during burst", 32'(spi_cs), 32'hD);
      wait_idle();
      chk("R10 lines inactive after burst", 32'(spi_cs), 32'hF);
      chk("R4 sclk back at cpol", 32'(spi_sclk), 32'(pol));
      rd(A_STAT, d);
      chk("R6 rx fill equals burst", 32'(d[6:0]), 32'(n));
      for (int i = 0; i < n; i++) begin
         rd(A_RXD, d);
         chk("R4 received byte msb first", d, 32'(s_tx[i]));
         chk("R4 sent byte msb first", 32'(s_rx[i]), 32'(8'(8'hA5 + i * 19 + m)));
      end
   endtask

   task automatic t_zero_fill_and_flush();
      logic [31:0] d;
      wr(A_CLK, 0);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h300);
      @(negedge clk);
      tb_cpol = 0; tb_cpha = 0; slave_reset(9);
      wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33); wr(A_TXD, 32'h44);
      rd(A_STAT, d); chk("R12 tx fill after four writes", 32'(d[22:16]), 4);
      wr(A_BURST, 4); wr(A_TXCNT, 2);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h400);
      wait_idle();
      chk("R5 byte0 from queue", 32'(s_rx[0]), 32'h11);
      chk("R5 byte1 from queue", 32'(s_rx[1]), 32'h22);
      chk("R5 byte2 past txcount is zero", 32'(s_rx[2]), 0);
      chk("R5 byte3 past txcount is zero", 32'(s_rx[3]), 0);
      rd(A_STAT, d);
      chk("R12 two bytes left queued", 32'(d[22:16]), 2);
      chk("R6 four bytes received", 32'(d[6:0]), 4);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h300);
      @(negedge clk);
      rd(A_CTRL, d); chk("R8 flush bits self clear", 32'(d[9:8]), 0);
      rd(A_STAT, d); chk("R8 both queues emptied", d, 0);
      // queue runs dry mid burst
      slave_reset(10);
      wr(A_TXD, 32'h5A);
      wr(A_BURST, 3); wr(A_TXCNT, 3);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h400);
      wait_idle();
      chk("R5 queued byte sent", 32'(s_rx[0]), 32'h5A);
      chk("R5 empty queue sends zero", 32'(s_rx[1]), 0);
      chk("R5 empty queue sends zero again", 32'(s_rx[2]), 0);
   endtask

   task automatic t_no_enable();
      logic [31:0] d;
      int e0;
      wr(A_CTRL, 32'h310);
      @(negedge clk);
      e0 = sclk_edges;
      wr(A_BURST, 2);
      wr(A_CTRL, 32'h412);
      repeat (60) @(negedge clk);
      rd(A_CTRL, d); chk("R3 no start without enable", 32'(d[10]), 0);
      chk("R3 no sclk edges without enable", 32'(sclk_edges - e0), 0);
      rd(A_STAT, d); chk("R3 nothing received without enable", d, 0);
   endtask

   task automatic t_rx_full();
      logic [31:0] d;
      wr(A_CLK, 0);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h300);
      @(negedge clk);
      tb_cpol = 0; tb_cpha = 0; slave_reset(3);
      wr(A_BURST, 63); wr(A_TXCNT, 0);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h400); wait_idle();
      wr(A_CTRL, cfg(0, 0, 0) | 32'h400); wait_idle();
      rd(A_STAT, d); chk("R7 rx fill saturates at 64", 32'(d[6:0]), 64);
      for (int i = 0; i < 64; i++) begin
         rd(A_RXD, d);
         chk("R7 oldest bytes kept", d, 32'(s_tx[i]));
      end
      rd(A_STAT, d); chk("R6 rx empty after draining", 32'(d[6:0]), 0);
   endtask

   task automatic t_manual_cs();
      wr(A_CTRL, 32'h0001_0010 | (2 << 12));
      chk("R9 manual low on line 2", 32'(spi_cs), 32'hB);
      wr(A_CTRL, 32'h0003_0010 | (2 << 12));
      chk("R9 manual high on line 2", 32'(spi_cs), 32'hF);
      wr(A_CTRL, 32'h0003_0000 | (3 << 12));
      chk("R9 manual high active-high line 3", 32'(spi_cs), 32'h8);
      wr(A_CTRL, 32'h0001_0000 | (3 << 12));
      chk("R9 manual low active-high line 3", 32'(spi_cs), 32'h0);
      wr(A_CTRL, 32'h0000_0000);
      chk("R10 auto idle active-high all low", 32'(spi_cs), 32'h0);
      wr(A_CTRL, 32'h10);
   endtask

   task automatic t_clkdiv(input int n);
      realtime t1, t2;
      wr(A_CLK, n);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h300);
      @(negedge clk);
      tb_cpol = 0; tb_cpha = 0; slave_reset(5);
      wr(A_BURST, 1); wr(A_TXCNT, 0);
      wr(A_CTRL, cfg(0, 0, 0) | 32'h400);
      @(posedge spi_sclk); t1 = $realtime;
      @(negedge spi_sclk); t2 = $realtime;
      chk("R11 half period equals div plus one", 32'(int'((t2 - t1) / 8.0)), 32'(n + 1));
      @(negedge clk);
      wait_idle();
      wr(A_CTRL, cfg(0, 0, 0) | 32'h200);
   endtask

   initial begin
      slave_reset(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counts();
      t_mode(0, 0, 5);
      t_mode(0, 1, 5);
      t_mode(1, 0, 4);
      t_mode(1, 1, 6);
      t_zero_fill_and_flush();
      t_no_enable();
      t_rx_full();
      t_manual_cs();
      t_clkdiv(4);
      t_clkdiv(0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule